// File: doc/BRIEF.md
# Watchdog Counter with Prewarning

This block is a supervision timer that software must service at regular intervals. A free-running prescaler divides the system clock by one of two ratios. On each prescaled tick an up-counter advances from a software-chosen start value. If the counter wraps past its top value, or if the neighbouring access unit reports a protocol error, the block does not reset the chip at once. It first sends a one-cycle non-maskable interrupt. It then reloads the counter with a fixed value and lets it run for a fixed grace period. When the counter wraps a second time, the block asserts the system reset request.

The reset request stays high for a fixed number of clock cycles. The block then resumes counting from zero. A flag records that a watchdog reset has occurred, and it survives that reset. If a second watchdog reset happens while the flag is still set, the block locks the reset request high until the power-on/hardware reset is applied. A valid service clears the flag. Software can switch off counting with a disable bit. Access errors are still handled while counting is disabled.

Top module: `wdog_prewarn`

## Requirements
- R1: While rst_n is low, and after it is released, nmi_o and sysrst_o are 0 and every bit of status_o is 0 until the first event.
- R2: In the running state with counting enabled, the count (status_o[CNT_W-1:0]) advances by one every 2^DIV_LO_LOG2 clocks when div_sel_i=0, and every 2^DIV_HI_LOG2 clocks when div_sel_i=1.
- R3: A one-cycle svc_i pulse in the running state loads reload_i into the count on the next clock. It also clears the watchdog-reset flag status_o[CNT_W+2].
- R4: In the running state with counting enabled, a tick while the count is all ones is an error.
- R5: An acc_err_i pulse in the running state is an error, whatever the value of wd_disable_i. An error takes priority over a service in the same cycle.
- R6: One cycle after an error, nmi_o is high for exactly one cycle. At that point the count equals 2^CNT_W - PREWARN_TICKS and the prewarning bit status_o[CNT_W] is 1.
- R7: During prewarning the count advances on every tick, whatever the value of wd_disable_i. svc_i and acc_err_i have no effect. sysrst_o rises when the count wraps, between (PREWARN_TICKS-1)*D+1 and PREWARN_TICKS*D cycles after nmi_o, where D is the selected division ratio.
- R8: In the running state with wd_disable_i=1, the count holds its value when there is no service and no error.
- R9: A first watchdog reset holds sysrst_o and status_o[CNT_W+1] high for exactly RST_PULSE cycles. The block then returns to the running state with the count at 0 and status_o[CNT_W+2] set.
- R10: A watchdog reset that occurs while status_o[CNT_W+2] is set locks the block: sysrst_o and status_o[CNT_W+3] stay high until rst_n is asserted. If the flag was cleared by a service in between, the block does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on/hardware reset, asynchronous, active low |
| svc_i | input | 1 | Service strobe, one cycle |
| reload_i | input | CNT_W | Start value loaded by a service |
| div_sel_i | input | 1 | Prescaler select: 0 = 2^DIV_LO_LOG2, 1 = 2^DIV_HI_LOG2 |
| wd_disable_i | input | 1 | 1 stops counting in the running state |
| acc_err_i | input | 1 | Access-error pulse from the access unit |
| nmi_o | output | 1 | Prewarning interrupt, one-cycle pulse |
| sysrst_o | output | 1 | System reset request |
| status_o | output | CNT_W+4 | Status: [CNT_W-1:0] count, [CNT_W] prewarning, [CNT_W+1] reset pulse, [CNT_W+2] watchdog-reset flag, [CNT_W+3] locked |

## Verification
The checker tests the following on every cycle:
- nmi_o is a single-cycle pulse, and it coincides with the prewarning bit and the fixed reload value.
- The reset request never rises except from prewarning.
- The lock state never releases on its own.
- A disabled running counter holds still.

Only the bench scenarios can show the end-to-end timing and the multi-event behaviour:
- the tick rate under each divider setting;
- the window from interrupt to reset;
- the exact length of the reset pulse;
- the different outcomes of two watchdog resets in a row, with and without a service between them.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WARN  = 2'd1,
    ST_PULSE = 2'd2,
    ST_LOCK  = 2'd3
  } wd_state_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int LO_LOG2 = 8,
  parameter int HI_LOG2 = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic tick_o
);
  logic [HI_LOG2-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // A tick marks the last cycle of each prescaler period.
  assign tick_o = sel_i ? (&pre_q) : (&pre_q[LO_LOG2-1:0]);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         inc;

  assign inc   = tick_i & en_i;
  assign ovf_o = inc & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)   cnt_d = load_val_i;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int W             = 16,
  parameter int PREWARN_TICKS = 256,
  parameter int RST_PULSE     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         svc_i,
  input  logic [W-1:0] reload_i,
  input  logic         dis_i,
  input  logic         acc_err_i,
  input  logic         ovf_i,
  output logic         count_en_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output wd_state_t    state_o,
  output logic         flag_o,
  output logic         nmi_o,
  output logic         sysrst_o
);
  localparam int HOLD_W = $clog2(RST_PULSE + 1);
  localparam logic [W-1:0] WARN_LOAD = '1 - W'(PREWARN_TICKS - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_PULSE - 1);

  wd_state_t          st_q, st_d;
  logic               flag_q, flag_d;
  logic               nmi_q, nmi_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;

  always_comb begin
    st_d       = st_q;
    flag_d     = flag_q;
    hold_d     = hold_q;
    nmi_d      = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    count_en_o = 1'b0;
    case (st_q)
      ST_RUN: begin
        count_en_o = !dis_i;
        if (acc_err_i || ovf_i) begin
          nmi_d      = 1'b1;
          load_o     = 1'b1;
          load_val_o = WARN_LOAD;
          st_d       = ST_WARN;
        end else if (svc_i) begin
          load_o     = 1'b1;
          load_val_o = reload_i;
          flag_d     = 1'b0;
        end
      end
      ST_WARN: begin
        count_en_o = 1'b1;
        if (ovf_i) begin
          hold_d = '0;
          if (flag_q) begin
            st_d = ST_LOCK;
          end else begin
            st_d   = ST_PULSE;
            flag_d = 1'b1;
          end
        end
      end
      ST_PULSE: begin
        if (hold_q == HOLD_LAST) begin
          st_d       = ST_RUN;
          load_o     = 1'b1;
          load_val_o = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      flag_q <= 1'b0;
      nmi_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
      nmi_q  <= nmi_d;
      hold_q <= hold_d;
    end
  end

  assign state_o  = st_q;
  assign flag_o   = flag_q;
  assign nmi_o    = nmi_q;
  assign sysrst_o = (st_q == ST_PULSE) || (st_q == ST_LOCK);
endmodule

// File: rtl/wdog_prewarn.sv
module wdog_prewarn
  import wdog_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DIV_LO_LOG2   = 8,
  parameter int DIV_HI_LOG2   = 14,
  parameter int PREWARN_TICKS = 256,
  parameter int RST_PULSE     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             div_sel_i,
  input  logic             wd_disable_i,
  input  logic             acc_err_i,
  output logic             nmi_o,
  output logic             sysrst_o,
  output logic [CNT_W+3:0] status_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tick, count_en, load, ovf, flag;
  logic [CNT_W-1:0] load_val, cnt;
  wd_state_t        state;

  // The reset asserts asynchronously and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdog_prescaler #(.LO_LOG2(DIV_LO_LOG2), .HI_LOG2(DIV_HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .sel_i(div_sel_i), .tick_o(tick)
  );

  wdog_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .en_i(count_en),
    .load_i(load), .load_val_i(load_val), .cnt_o(cnt), .ovf_o(ovf)
  );

  wdog_ctrl #(.W(CNT_W), .PREWARN_TICKS(PREWARN_TICKS), .RST_PULSE(RST_PULSE)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .svc_i(svc_i), .reload_i(reload_i),
    .dis_i(wd_disable_i), .acc_err_i(acc_err_i), .ovf_i(ovf),
    .count_en_o(count_en), .load_o(load), .load_val_o(load_val),
    .state_o(state), .flag_o(flag), .nmi_o(nmi_o), .sysrst_o(sysrst_o)
  );

  assign status_o = {state == ST_LOCK, flag, state == ST_PULSE, state == ST_WARN, cnt};
endmodule

// File: rtl/wdog_prewarn_chk.sv
module wdog_prewarn_chk #(
  parameter int CNT_W         = 16,
  parameter int PREWARN_TICKS = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             svc_i,
  input logic             wd_disable_i,
  input logic             acc_err_i,
  input logic             nmi_o,
  input logic             sysrst_o,
  input logic [CNT_W+3:0] status_o
);
  localparam logic [CNT_W-1:0] WARN_LOAD = '1 - CNT_W'(PREWARN_TICKS - 1);

  logic running;
  assign running = (status_o[CNT_W+3:CNT_W] == 4'b0000) ||
                   (status_o[CNT_W+3:CNT_W] == 4'b0100);

  // R6
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o);

  // R6
  nmi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> (status_o[CNT_W] && !sysrst_o && status_o[CNT_W-1:0] == WARN_LOAD));

  // R7
  rst_from_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysrst_o) |-> $past(status_o[CNT_W]));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wd_disable_i && !svc_i && !acc_err_i) |=> $stable(status_o[CNT_W-1:0]));

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[CNT_W+3] |=> (status_o[CNT_W+3] && sysrst_o));
endmodule

bind wdog_prewarn wdog_prewarn_chk #(.CNT_W(CNT_W), .PREWARN_TICKS(PREWARN_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .svc_i(svc_i), .wd_disable_i(wd_disable_i),
  .acc_err_i(acc_err_i), .nmi_o(nmi_o), .sysrst_o(sysrst_o), .status_o(status_o)
);

// File: tb/test_wdog_prewarn.sv
module test_wdog_prewarn;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int LO  = 2;
  localparam int HI  = 4;
  localparam int PT  = 4;
  localparam int RP  = 4;
  localparam int B_WARN = CW, B_PULSE = CW + 1, B_FLAG = CW + 2, B_LOCK = CW + 3;

  typedef struct packed { int kind; int lo; int hi; } ev_t;

  logic clk = 1'b0;
  logic rst_n, svc_i, div_sel_i, wd_disable_i, acc_err_i;
  logic [CW-1:0] reload_i;
  logic nmi_o, sysrst_o;
  logic [CW+3:0] status_o;

  int checks = 0, fails = 0, cyc = 0, nmi_cyc = 0, rst_cyc = 0;
  ev_t q[$];
  logic p_nmi = 1'b0, p_rst = 1'b0, p_lock = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_prewarn #(.CNT_W(CW), .DIV_LO_LOG2(LO), .DIV_HI_LOG2(HI),
                 .PREWARN_TICKS(PT), .RST_PULSE(RP)) i_wdog_prewarn (
    .clk(clk), .rst_n(rst_n), .svc_i(svc_i), .reload_i(reload_i),
    .div_sel_i(div_sel_i), .wd_disable_i(wd_disable_i), .acc_err_i(acc_err_i),
    .nmi_o(nmi_o), .sysrst_o(sysrst_o), .status_o(status_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_error_seq(input bit with_rst);
    int d;
    ev_t e;
    d = div_sel_i ? (1 << HI) : (1 << LO);
    e.kind = 0; e.lo = 0; e.hi = 0;
    q.push_back(e);
    if (with_rst) begin
      e.kind = 1; e.lo = (PT - 1) * d + 1; e.hi = PT * d;
      q.push_back(e);
    end
  endtask

  task automatic pulse_svc(input logic [CW-1:0] v);
    reload_i = v; svc_i = 1'b1;
    @(negedge clk); svc_i = 1'b0;
  endtask

  task automatic pulse_err();
    acc_err_i = 1'b1;
    @(negedge clk); acc_err_i = 1'b0;
  endtask

  task automatic wait_rst_rise();
    while (!sysrst_o) @(negedge clk);
  endtask

  task automatic wait_rst_fall();
    while (sysrst_o) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!nmi_o && !sysrst_o && status_o == '0, "R1 in reset", int'(status_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops expected events as the outputs change.
  always @(negedge clk) begin
    ev_t e;
    cyc++;
    if (nmi_o && !p_nmi) begin
      if (q.size() == 0) chk(1'b0, "R6 unexpected nmi", 1, 0);
      else begin
        e = q.pop_front();
        chk(e.kind == 0, "R6 nmi order", 0, e.kind);
        nmi_cyc = cyc;
      end
    end
    if (sysrst_o && !p_rst) begin
      rst_cyc = cyc;
      if (q.size() == 0) chk(1'b0, "R7 unexpected reset", 1, 0);
      else begin
        e = q.pop_front();
        chk(e.kind == 1, "R7 reset order", 1, e.kind);
        chk(cyc - nmi_cyc >= e.lo && cyc - nmi_cyc <= e.hi, "R7 nmi to reset delay",
            cyc - nmi_cyc, e.hi);
      end
    end
    if (!sysrst_o && p_rst && !p_lock && rst_n)
      chk(cyc - rst_cyc == RP, "R9 reset pulse width", cyc - rst_cyc, RP);
    p_nmi  = nmi_o;
    p_rst  = sysrst_o;
    p_lock = status_o[B_LOCK];
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; svc_i = 1'b0; reload_i = '0; div_sel_i = 1'b0;
    wd_disable_i = 1'b0; acc_err_i = 1'b0;
    @(negedge clk);
    do_reset();
    chk(status_o == '0 && !nmi_o && !sysrst_o, "R1 after release", int'(status_o), 0);

    // R3 service load
    pulse_svc(8'h40);
    chk(status_o[CW-1:0] == 8'h40, "R3 reload", int'(status_o[CW-1:0]), 8'h40);

    // R2 tick rates
    c0 = int'(status_o[CW-1:0]);
    repeat (1 << LO) @(negedge clk);
    chk(int'(status_o[CW-1:0]) == c0 + 1, "R2 low divider", int'(status_o[CW-1:0]), c0 + 1);
    div_sel_i = 1'b1;
    @(negedge clk);
    c0 = int'(status_o[CW-1:0]);
    repeat (1 << HI) @(negedge clk);
    chk(int'(status_o[CW-1:0]) == c0 + 1, "R2 high divider", int'(status_o[CW-1:0]), c0 + 1);
    div_sel_i = 1'b0;

    // R8 disabled counter holds
    wd_disable_i = 1'b1;
    pulse_svc(8'h40);
    repeat (200) @(negedge clk);
    chk(status_o[CW-1:0] == 8'h40, "R8 disabled hold", int'(status_o[CW-1:0]), 8'h40);

    // R5 access error while disabled, R6 prewarning entry
    expect_error_seq(1'b1);
    pulse_err();
    chk(nmi_o == 1'b1, "R5 nmi on access error", int'(nmi_o), 1);
    chk(status_o[CW-1:0] == 8'hFC && status_o[B_WARN], "R6 fixed reload",
        int'(status_o[CW-1:0]), 8'hFC);
    @(negedge clk);
    chk(nmi_o == 1'b0, "R6 nmi one cycle", int'(nmi_o), 0);
    // R7 service and error ignored in prewarning
    pulse_svc(8'h10);
    pulse_err();
    chk(status_o[CW-1:0] >= 8'hFC && status_o[B_WARN], "R7 service ignored",
        int'(status_o[CW-1:0]), 8'hFC);
    wait_rst_rise();
    chk(status_o[B_PULSE] == 1'b1, "R9 pulse bit", int'(status_o[B_PULSE]), 1);
    wait_rst_fall();
    chk(status_o[CW-1:0] == 0 && status_o[B_FLAG] && !status_o[B_LOCK], "R9 resume with flag",
        int'(status_o), 1 << B_FLAG);

    // R10 second reset without service locks
    expect_error_seq(1'b1);
    pulse_err();
    wait_rst_rise();
    repeat (50) @(negedge clk);
    chk(sysrst_o && status_o[B_LOCK], "R10 locked", int'(status_o[B_LOCK]), 1);
    do_reset();
    chk(status_o == '0 && !sysrst_o, "R1 lock cleared by rst_n", int'(status_o), 0);

    // R4 overflow in running state
    wd_disable_i = 1'b0;
    expect_error_seq(1'b1);
    pulse_svc(8'hF0);
    wait_rst_rise();
    wait_rst_fall();
    chk(status_o[B_FLAG] == 1'b1, "R4 overflow reset flag", int'(status_o[B_FLAG]), 1);
    pulse_svc(8'h20);
    chk(status_o[B_FLAG] == 1'b0, "R3 service clears flag", int'(status_o[B_FLAG]), 0);

    // R10 negative: after service, a second reset does not lock (high divider)
    div_sel_i = 1'b1;
    expect_error_seq(1'b1);
    pulse_err();
    wait_rst_rise();
    wait_rst_fall();
    chk(!sysrst_o && !status_o[B_LOCK], "R10 no lock after service",
        int'(status_o[B_LOCK]), 0);

    // R5 error wins over service in the same cycle
    div_sel_i = 1'b0;
    expect_error_seq(1'b0);
    reload_i = 8'h33; svc_i = 1'b1; acc_err_i = 1'b1;
    @(negedge clk); svc_i = 1'b0; acc_err_i = 1'b0;
    chk(status_o[CW-1:0] == 8'hFC && nmi_o, "R5 error priority", int'(status_o[CW-1:0]), 8'hFC);
    do_reset();

    chk(q.size() == 0, "R7 all events seen", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule